// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Handover

This block picks which of two free-running clocks drives the device clock and moves between them without ever producing a shortened high or low phase. Source 0 (`clk_a`) is the primary clock and source 1 (`clk_b`) is the alternate. A level request (`sel_req`) names the wanted source. Each source has a ready level that says its oscillator is stable. The outgoing clock keeps driving the output until the incoming source is ready and the handshake between the two domains has finished.

Each source has a control slice that runs in its own clock domain. The slice holds a committed target, a short enable chain and a gate. The outgoing slice drops its enable through a two-stage path. The incoming slice raises its enable through a three-stage path, and only after it has seen the outgoing enable low. Each gate closes or opens only while its clock is low, and the two gated clocks are ORed together. When the incoming enable turns on, a one-cycle pulse in the new clock domain reports that the handover is complete, so status can be updated in step with it.

Top module: `clk_handover_mux`

## Requirements
- R1: Reset makes `clk_a` the device clock directly, with no handshake. It produces no `sw_done` pulse, and after release every device clock pulse comes from `clk_a`.
- R2: While the requested source's ready input is low, the device clock stays on the current source and no `sw_done` pulse is produced.
- R3: Once the request is committed and the incoming ready input rises, the outgoing clock delivers exactly two more pulses. These are the pulses on its first two rising edges after ready.
- R4: The first pulse of the incoming clock arrives on its third or fourth rising edge, counted after the rising edge of the last outgoing pulse.
- R5: The two source enables are never high together. Every device clock high phase is a full high phase of one source, and every low phase lasts at least the shorter half period.
- R6: Each completed handover gives exactly one `sw_done` pulse, one incoming-clock cycle wide, and it is high only after the outgoing enable is off.
- R7: A gate enable seen by the clock AND changes only while that gate's clock is low.
- R8: A change of `sel_req` after a handover has been committed does not cancel it. The committed handover completes, and the new level is taken up only after its `sw_done`.
- R9: A handover from `clk_b` back to `clk_a` follows the same rules and ends with steady `clk_a` pulses and one `sw_done` pulse one `clk_a` cycle wide.
- R10: Reset while `clk_b` is the device clock returns the output to `clk_a` with no `sw_done` pulse.

`sel_req` encodes 0 for `clk_a` and 1 for `clk_b`. It must be held until the matching `sw_done`. A ready input must stay high while its source is in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Primary source clock (source 0) |
| clk_b | input | 1 | Alternate source clock (source 1) |
| rst | input | 1 | Active-high reset, synchronous in each clock domain; held for several cycles of both clocks |
| sel_req | input | 1 | Requested source: 0 = `clk_a`, 1 = `clk_b`; level, held until done |
| rdy_a | input | 1 | `clk_a` is stable and may be used |
| rdy_b | input | 1 | `clk_b` is stable and may be used |
| dev_clk | output | 1 | Glitch-free device clock |
| sw_done | output | 1 | One-cycle pulse in the incoming clock domain when a handover completes |

## Verification
The two source clocks have periods of 8 ns and 14 ns, and their rising edges never coincide. Each device clock pulse can therefore be traced to its source by its high width: 4 ns for `clk_a` and 7 ns for `clk_b`. After `rdy_b` is raised just past a `clk_a` falling edge, exactly two `clk_a` pulses are expected. The first `clk_b` pulse is expected on the third or fourth `clk_b` rising edge after the last `clk_a` pulse began. The `sw_done` high time must equal one period of the incoming clock. All counts and levels are sampled 1 ns after a falling edge, when every pulse that is due has already closed, so no check races the edge that produced it.

// File: rtl/cksw_pkg.sv
package cksw_pkg;

    // Source count and the index that reset selects without a handshake.
    localparam int NUM_SRC        = 2;
    localparam int PRIMARY        = 0;

    // Enable chain depths: stages to turn a source off and to turn it on.
    localparam int OFF_STAGES_DEF = 2;
    localparam int ON_STAGES_DEF  = 3;

    // Local view of one slice used to decide if its committed target may move.
    typedef struct packed {
        logic mine;        // committed target is this slice's source
        logic seen_other;  // other slice's enable, synchronised here
        logic en;          // this slice's own enable
    } slice_view_t;

    // A slice is at rest when its own enable and the other's agree with its target.
    function automatic logic slice_settled(input slice_view_t v);
        return v.mine ? (v.en & ~v.seen_other) : (~v.en & v.seen_other);
    endfunction

    // Next value entering the enable chain.
    function automatic logic chain_input(input logic mine,
                                         input logic claim_other,
                                         input logic en_other);
        return (mine | ~claim_other) & ~en_other;
    endfunction

endpackage

// File: rtl/cksw_sync.sv
module cksw_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= {STAGES{RST_VAL}};
        else     ff <= {ff[STAGES-2:0], d};
    end

    assign q = ff[STAGES-1];
endmodule

// File: rtl/cksw_gate.sv
module cksw_gate (
    input  logic clk,
    input  logic en,
    output logic en_lat,
    output logic gclk
);
    // Transparent while the clock is low, so the gate opens or closes only in the low phase.
    always_latch begin
        if (!clk) en_lat = en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/cksw_slice.sv
module cksw_slice
    import cksw_pkg::*;
#(
    parameter bit OWN_PRIMARY = 1'b0,
    parameter int ON_STAGES   = ON_STAGES_DEF,
    parameter int OFF_STAGES  = OFF_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic sel_me,
    input  logic rdy_own,
    input  logic claim_other,
    input  logic en_other,
    output logic en,
    output logic claim,
    output logic done,
    output logic en_lat,
    output logic gclk
);
    logic        sel_s;
    logic        seen_other;
    logic        mine_q;
    logic        prev_en;
    slice_view_t view;
    logic [ON_STAGES-1:0] stg;

    // Request and the other slice's enable brought into this domain.
    cksw_sync #(.STAGES(2), .RST_VAL(OWN_PRIMARY)) u_sel (
        .clk(clk), .rst(rst), .d(sel_me), .q(sel_s)
    );
    cksw_sync #(.STAGES(2), .RST_VAL(!OWN_PRIMARY)) u_seen (
        .clk(clk), .rst(rst), .d(en_other), .q(seen_other)
    );

    assign view = '{mine: mine_q, seen_other: seen_other, en: en};

    // Committed target: frozen from commit until this slice's part of the handover is done.
    always_ff @(posedge clk) begin
        if (rst)                      mine_q <= OWN_PRIMARY;
        else if (slice_settled(view)) mine_q <= sel_s;
    end

    // Enable chain: the first stage also resynchronises the other domain's signals.
    always_ff @(posedge clk) begin
        if (rst) stg <= {ON_STAGES{OWN_PRIMARY}};
        else     stg <= {stg[ON_STAGES-2:0], chain_input(mine_q, claim_other, en_other)};
    end

    // A rise needs the full depth; a fall shows as soon as the shorter tap drops.
    assign en = stg[ON_STAGES-1] & stg[OFF_STAGES-1];

    // This source asks for the clock only when it is committed and ready.
    assign claim = mine_q & rdy_own;

    always_ff @(posedge clk) begin
        if (rst) prev_en <= OWN_PRIMARY;
        else     prev_en <= en;
    end

    assign done = en & ~prev_en;

    cksw_gate u_gate (
        .clk(clk), .en(en), .en_lat(en_lat), .gclk(gclk)
    );
endmodule

// File: rtl/clk_handover_mux.sv
module clk_handover_mux
    import cksw_pkg::*;
#(
    parameter int ON_STAGES  = ON_STAGES_DEF,
    parameter int OFF_STAGES = OFF_STAGES_DEF
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst,
    input  logic sel_req,
    input  logic rdy_a,
    input  logic rdy_b,
    output logic dev_clk,
    output logic sw_done
);
    logic [NUM_SRC-1:0] clk_v;
    logic [NUM_SRC-1:0] sel_me;
    logic [NUM_SRC-1:0] rdy_v;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] claim_v;
    logic [NUM_SRC-1:0] done_v;
    logic [NUM_SRC-1:0] en_lat;
    logic [NUM_SRC-1:0] gclk_v;

    assign clk_v  = {clk_b, clk_a};
    assign sel_me = {sel_req, ~sel_req};
    assign rdy_v  = {rdy_b, rdy_a};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int OTH = NUM_SRC - 1 - i;
        cksw_slice #(
            .OWN_PRIMARY(i == PRIMARY),
            .ON_STAGES  (ON_STAGES),
            .OFF_STAGES (OFF_STAGES)
        ) u_slice (
            .clk        (clk_v[i]),
            .rst        (rst),
            .sel_me     (sel_me[i]),
            .rdy_own    (rdy_v[i]),
            .claim_other(claim_v[OTH]),
            .en_other   (en_q[OTH]),
            .en         (en_q[i]),
            .claim      (claim_v[i]),
            .done       (done_v[i]),
            .en_lat     (en_lat[i]),
            .gclk       (gclk_v[i])
        );
    end

    assign dev_clk = |gclk_v;
    assign sw_done = |done_v;
endmodule

// File: rtl/cksw_checker.sv
module cksw_checker (
    input logic       clk_a,
    input logic       clk_b,
    input logic       rst,
    input logic       rdy_a,
    input logic       rdy_b,
    input logic [1:0] en_q,
    input logic [1:0] done_v,
    input logic [1:0] en_lat
);
    assert_exclusive_a_R5: assert property (@(posedge clk_a) disable iff (rst)
        !(en_q[0] && en_q[1]));
    assert_exclusive_b_R5: assert property (@(posedge clk_b) disable iff (rst)
        !(en_q[0] && en_q[1]));

    // R2: the outgoing enable drops only after the incoming source was ready.
    assert_yield_needs_ready_a_R2: assert property (@(posedge clk_a) disable iff (rst)
        $fell(en_q[0]) |-> $past(rdy_b));
    assert_yield_needs_ready_b_R2: assert property (@(posedge clk_b) disable iff (rst)
        $fell(en_q[1]) |-> $past(rdy_a));

    assert_done_one_cycle_b_R6: assert property (@(posedge clk_b) disable iff (rst)
        done_v[1] |=> !done_v[1]);
    assert_done_one_cycle_a_R6: assert property (@(posedge clk_a) disable iff (rst)
        done_v[0] |=> !done_v[0]);
    assert_done_old_off_b_R6: assert property (@(posedge clk_b) disable iff (rst)
        done_v[1] |-> !en_q[0]);
    assert_done_old_off_a_R6: assert property (@(posedge clk_a) disable iff (rst)
        done_v[0] |-> !en_q[1]);

    always @(en_lat[0]) begin
        if (!rst) begin
            assert_gate_low_a_R7: assert (clk_a == 1'b0)
                else $error("gate a enable moved while clk_a high");
        end
    end
    always @(en_lat[1]) begin
        if (!rst) begin
            assert_gate_low_b_R7: assert (clk_b == 1'b0)
                else $error("gate b enable moved while clk_b high");
        end
    end
endmodule

bind clk_handover_mux cksw_checker u_chk (
    .clk_a (clk_a),
    .clk_b (clk_b),
    .rst   (rst),
    .rdy_a (rdy_a),
    .rdy_b (rdy_b),
    .en_q  (en_q),
    .done_v(done_v),
    .en_lat(en_lat)
);

// File: tb/sim_clk_handover_mux.sv
`timescale 1ns/1ps
module sim_clk_handover_mux;
    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic rst = 1'b1;
    logic sel_req = 1'b0;
    logic rdy_a = 1'b1;
    logic rdy_b = 1'b0;
    logic dev_clk;
    logic sw_done;

    int tests = 0;
    int failed = 0;

    clk_handover_mux u0 (
        .clk_a(clk_a), .clk_b(clk_b), .rst(rst), .sel_req(sel_req),
        .rdy_a(rdy_a), .rdy_b(rdy_b), .dev_clk(dev_clk), .sw_done(sw_done)
    );

    // 125 MHz primary; alternate 14 ns with odd rising times, so edges never coincide.
    initial forever #4 clk_a = ~clk_a;
    initial begin
        #3;
        forever begin
            clk_b = 1'b1; #7;
            clk_b = 1'b0; #7;
        end
    end

    // Pulse monitor: the high width tells the source (4 ns = a, 7 ns = b).
    int     a_pulses = 0, b_pulses = 0, glitches = 0;
    int     nb = 0, nb_at_rise = 0, last_a_nb = 0, first_b_gap = -1;
    bit     want_first_b = 1'b0, mon_en = 1'b0;
    longint t_rise = 0, t_fall = 0, t_done = 0;
    int     done_cnt = 0, done_w = 0;

    always @(posedge clk_b) nb++;

    always @(posedge dev_clk) begin
        if (mon_en && (($time - t_fall) < 4)) glitches++;
        t_rise = $time;
        nb_at_rise = nb;
    end

    always @(negedge dev_clk) begin
        longint w;
        w = $time - t_rise;
        t_fall = $time;
        if (w == 4) begin
            a_pulses++;
            last_a_nb = nb_at_rise;
        end else if (w == 7) begin
            b_pulses++;
            if (want_first_b) begin
                first_b_gap = nb - last_a_nb;
                want_first_b = 1'b0;
            end
        end else if (mon_en) begin
            glitches++;
        end
    end

    always @(posedge sw_done) begin
        t_done = $time;
        done_cnt++;
    end
    always @(negedge sw_done) done_w = int'($time - t_done);

    task automatic check(input bit ok, input string req, input int act, input int exp,
                         input string what);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        a_pulses = 0;
        b_pulses = 0;
        done_cnt = 0;
    endtask

    task automatic steady_a(input string req, input int n);
        @(negedge clk_a); #1;
        clear_counts();
        repeat (n) @(negedge clk_a);
        #1;
        check(a_pulses == n, req, a_pulses, n, "steady clk_a pulses");
        check(b_pulses == 0, req, b_pulses, 0, "no clk_b pulses");
    endtask

    task automatic steady_b(input string req, input int n);
        @(negedge clk_b); #1;
        clear_counts();
        repeat (n) @(negedge clk_b);
        #1;
        check(b_pulses == n, req, b_pulses, n, "steady clk_b pulses");
        check(a_pulses == 0, req, a_pulses, 0, "no clk_a pulses");
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (10) @(negedge clk_b);
        #1 rst = 1'b0;
        repeat (6) @(negedge clk_a);
        #1;
        clear_counts();
        mon_en = 1'b1;
        repeat (10) @(negedge clk_a);
        #1;
        check(a_pulses == 10, "R1", a_pulses, 10, "clk_a drives after reset");
        check(b_pulses == 0, "R1", b_pulses, 0, "no clk_b after reset");
        check(done_cnt == 0, "R1", done_cnt, 0, "no done after reset");
    endtask

    task automatic t_wait_ready();
        @(negedge clk_a); #1;
        sel_req = 1'b1;
        clear_counts();
        repeat (30) @(negedge clk_a);
        #1;
        check(a_pulses == 30, "R2", a_pulses, 30, "clk_a holds while rdy_b low");
        check(b_pulses == 0, "R2", b_pulses, 0, "no clk_b while rdy_b low");
        check(done_cnt == 0, "R2", done_cnt, 0, "no done while rdy_b low");
    endtask

    task automatic t_switch_in();
        @(negedge clk_a); #1;
        clear_counts();
        want_first_b = 1'b1;
        first_b_gap = -1;
        rdy_b = 1'b1;
        repeat (20) @(negedge clk_b);
        #1;
        check(a_pulses == 2, "R3", a_pulses, 2, "clk_a pulses after ready");
        check(first_b_gap >= 3 && first_b_gap <= 4, "R4", first_b_gap, 4,
              "clk_b edge of first new pulse");
        check(done_cnt == 1, "R6", done_cnt, 1, "one done per handover");
        check(done_w == 14, "R6", done_w, 14, "done width in ns");
        steady_b("R5", 10);
    endtask

    task automatic t_ignore_during();
        @(negedge clk_b); #1;
        rdy_a = 1'b0;
        sel_req = 1'b0;
        clear_counts();
        repeat (20) @(negedge clk_b);
        #1;
        check(a_pulses == 0, "R2", a_pulses, 0, "held on clk_b while rdy_a low");
        check(done_cnt == 0, "R2", done_cnt, 0, "no done while rdy_a low");
        // Committed to clk_a; the request flips back but must not cancel it.
        sel_req = 1'b1;
        repeat (10) @(negedge clk_b);
        #1 rdy_a = 1'b1;
        repeat (60) @(negedge clk_b);
        #1;
        check(a_pulses >= 1, "R8", a_pulses, 1, "committed handover to clk_a happened");
        check(done_cnt == 2, "R8", done_cnt, 2, "handover then follow-up");
        steady_b("R8", 10);
    endtask

    task automatic t_switch_back();
        @(negedge clk_b); #1;
        sel_req = 1'b0;
        clear_counts();
        repeat (40) @(negedge clk_b);
        #1;
        check(done_cnt == 1, "R9", done_cnt, 1, "one done on return to clk_a");
        check(done_w == 8, "R9", done_w, 8, "done width in ns");
        steady_a("R9", 10);
    endtask

    task automatic t_reset_from_b();
        @(negedge clk_a); #1;
        sel_req = 1'b1;
        repeat (40) @(negedge clk_b);
        steady_b("R10", 5);
        mon_en = 1'b0;
        sel_req = 1'b0;
        rst = 1'b1;
        repeat (10) @(negedge clk_b);
        #1 rst = 1'b0;
        repeat (6) @(negedge clk_a);
        #1;
        clear_counts();
        mon_en = 1'b1;
        repeat (10) @(negedge clk_a);
        #1;
        check(a_pulses == 10, "R10", a_pulses, 10, "clk_a after reset from clk_b");
        check(b_pulses == 0, "R10", b_pulses, 0, "no clk_b after reset");
        check(done_cnt == 0, "R10", done_cnt, 0, "reset gives no done");
    endtask

    initial begin
        #200000;
        tests++;
        failed++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        t_reset();
        t_wait_ready();
        t_switch_in();
        t_ignore_during();
        t_switch_back();
        t_reset_from_b();
        // R5 R7: every monitored phase had full width.
        check(glitches == 0, "R5 R7", glitches, 0, "runt phases on dev_clk");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule